// File: doc/BRIEF.md
# Parallel CRC-16 Word Engine

This block keeps a running 16-bit cyclic redundancy check and absorbs a complete data word into it in a single clock cycle. The result is the same as clocking a one-bit linear feedback shift register once for every data bit, taking the most significant data bit first. The default generator is x^16 + x^12 + x^5 + 1.

A framing layer pulses `init` at the start of each message and raises `valid` for each data word. It reads `crcOut` as the running check value. If `init` and `valid` are high in the same cycle, that word becomes the first word of a new message. The XOR network is not written out by hand. The RTL builds it by chaining copies of one single-bit step, so changing the data width or the polynomial only means changing a parameter. Final inversion, bit reflection and message framing belong to the surrounding logic.

Top module: `crc16_engine`

## Requirements
- R1: While `rstN` is low the register is forced to the preset value (default 16'hFFFF), asynchronously.
- R2: A cycle with `valid` and `init` both low leaves `crcOut` unchanged, whatever is on `dataIn`.
- R3: One single-bit step shifts the register left by one place and puts 0 in bit 0. If the old bit 15 XOR the data bit is 1, it then XORs the polynomial mask (default 16'h1021). From 16'h1111 with data bit 1 the result is 16'h3203.
- R4: A valid word is absorbed as DATA_W single-bit steps in a row. The steps start at `dataIn[DATA_W-1]` and end at `dataIn[0]`, and each step starts from the result of the one before it. With the default preset, the bytes of the ASCII string "123456789" give 16'h29B1.
- R5: The new value appears on `crcOut` at the first rising clock edge after `valid` is sampled, and not before that edge.
- R6: `init` with `valid` low loads the preset value at the next edge.
- R7: `init` and `valid` together load the preset value with that cycle's word already absorbed into it.
- R8: The same rule holds for every data width. A 1-bit, an 8-bit and a 16-bit instance each match a serial model over their own widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low, loads the preset value |
| init | input | 1 | Synchronous restart to the preset value |
| valid | input | 1 | Qualifies `dataIn` for absorption this cycle |
| dataIn | input | DATA_W | Data word, most significant bit absorbed first |
| crcOut | output | 16 | Running CRC register |

## Verification
Every result is due exactly one rising edge after the cycle that presents it. This covers an absorbed word, a preset load and an idle hold. The bench drives inputs on the falling edge and compares on the next falling edge, after the single register has updated. A few nanoseconds after driving, and before the rising edge, it also confirms that `crcOut` still holds its old value. During reset the outputs are compared while `rstN` is still low, with no clock edge needed.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic loadPreset;  // restart from the preset value
    logic foldWord;    // absorb the data word this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic         init,
  input  logic         valid,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.loadPreset = init;
    strobes.foldWord   = valid;
  end

endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int                 DATA_W = 16,
  parameter int                 CRC_W  = 16,
  parameter logic [CRC_W-1:0]   POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]   PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcQ
);

  localparam int STAGES = DATA_W;

  // One serial step: shift left, then apply the mask if feedback is set
  function automatic logic [CRC_W-1:0] bitStep(input logic [CRC_W-1:0] cur,
                                               input logic             dBit);
    logic [CRC_W-1:0] nxt;
    nxt = {cur[CRC_W-2:0], 1'b0};
    if (cur[CRC_W-1] ^ dBit) nxt = nxt ^ POLY;
    return nxt;
  endfunction

  logic [CRC_W-1:0] baseVal;
  logic [CRC_W-1:0] chain [STAGES+1];
  logic [CRC_W-1:0] crcD;
  logic             regEn;

  assign baseVal  = strobes.loadPreset ? PRESET : crcQ;
  assign chain[0] = baseVal;

  // Unrolled chain, most significant data bit enters first
  for (genvar k = 0; k < STAGES; k++) begin : g_step
    assign chain[k+1] = bitStep(chain[k], dataIn[DATA_W-1-k]);
  end

  assign crcD  = strobes.foldWord ? chain[STAGES] : baseVal;
  assign regEn = strobes.foldWord | strobes.loadPreset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      crcQ <= PRESET;
    else if (regEn) crcQ <= crcD;
  end

endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter int                CRC_W  = 16,
  parameter int                POLY_W = 16,
  parameter logic [POLY_W-1:0] POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]  PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              init,
  input  logic              valid,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcOut
);

  // The mask and the register must have the same width
  if (POLY_W != CRC_W) begin : g_width_check
    $error("crc16_engine: POLY_W must equal CRC_W");
  end

  ctrlStrobes_t strobes;

  crc16_ctrl u_ctrl (
    .init    (init),
    .valid   (valid),
    .strobes (strobes)
  );

  crc16_datapath #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W),
    .POLY   (CRC_W'(POLY)),
    .PRESET (PRESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .crcQ    (crcOut)
  );

endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk #(
  parameter int                DATA_W = 16,
  parameter int                CRC_W  = 16,
  parameter int                POLY_W = 16,
  parameter logic [POLY_W-1:0] POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]  PRESET = 16'hFFFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              init,
  input logic              valid,
  input logic [DATA_W-1:0] dataIn,
  input logic [CRC_W-1:0]  crcOut
);

  // Serial reference, walking the word from its top bit downward
  function automatic logic [CRC_W-1:0] serialRef(input logic [CRC_W-1:0]  start,
                                                 input logic [DATA_W-1:0] word);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = start;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ word[i];
      r  = r << 1;
      if (fb) r = r ^ CRC_W'(POLY);
    end
    return r;
  endfunction

  AST_KNOWN_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(crcOut)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!valid && !init) |=> $stable(crcOut)); // R2

  AST_WORD_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !init) |=> crcOut == serialRef($past(crcOut), $past(dataIn))); // R4

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (init && !valid) |=> crcOut == PRESET); // R6

  AST_INIT_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (init && valid) |=> crcOut == serialRef(PRESET, $past(dataIn))); // R7

endmodule

bind crc16_engine crc16_engine_chk #(
  .DATA_W (DATA_W),
  .CRC_W  (CRC_W),
  .POLY_W (POLY_W),
  .POLY   (POLY),
  .PRESET (PRESET)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .init   (init),
  .valid  (valid),
  .dataIn (dataIn),
  .crcOut (crcOut)
);

// File: tb/crc16_engine_bench.sv
module crc16_engine_bench;

  localparam logic [15:0] MASK      = 16'h1021;
  localparam logic [15:0] PRESET_A  = 16'hFFFF;
  localparam logic [15:0] PRESET_B  = 16'h1111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        init = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] d16 = '0;
  logic [7:0]  d8 = '0;
  logic [0:0]  d1 = '0;
  logic [15:0] out16, out8, out1;
  logic [15:0] m16, m8, m1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  crc16_engine #(.DATA_W(16)) u_crc16_engine (
    .clk(clk), .rstN(rstN), .init(init), .valid(valid), .dataIn(d16), .crcOut(out16));

  crc16_engine #(.DATA_W(8)) u_w8 (
    .clk(clk), .rstN(rstN), .init(init), .valid(valid), .dataIn(d8), .crcOut(out8));

  crc16_engine #(.DATA_W(1), .PRESET(PRESET_B)) u_w1 (
    .clk(clk), .rstN(rstN), .init(init), .valid(valid), .dataIn(d1), .crcOut(out1));

  // Bit-serial model: n steps, top bit of the n-bit word first
  function automatic logic [15:0] serial(input logic [15:0] c, input logic [15:0] w, input int n);
    logic [15:0] r = c;
    for (int i = n - 1; i >= 0; i--) begin
      if (r[15] ^ w[i]) r = {r[14:0], 1'b0} ^ MASK;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, check the old value holds before the rising
  // edge, then compare against the models at the next falling edge.
  task automatic step(input logic i, input logic v, input logic [15:0] w16,
                      input logic [7:0] w8, input logic w1, input string req);
    logic [15:0] o16, o8, o1;
    o16 = out16; o8 = out8; o1 = out1;
    init = i; valid = v; d16 = w16; d8 = w8; d1 = w1;
    if (i) begin m16 = PRESET_A; m8 = PRESET_A; m1 = PRESET_B; end
    if (v) begin
      m16 = serial(m16, w16, 16);
      m8  = serial(m8, {8'h00, w8}, 8);
      m1  = serial(m1, {15'h0, w1}, 1);
    end
    #2;
    check("R5", out16, o16);
    check("R5", out8, o8);
    check("R5", out1, o1);
    @(negedge clk);
    check(req, out16, m16);
    check(req, out8, m8);
    check(req, out1, m1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string msg;
    logic [15:0] w;
    void'($urandom(32'd1234));
    m16 = PRESET_A; m8 = PRESET_A; m1 = PRESET_B;

    // R1: reset values while rstN is low
    repeat (3) @(negedge clk);
    check("R1", out16, PRESET_A);
    check("R1", out8, PRESET_A);
    check("R1", out1, PRESET_B);
    rstN = 1'b1;
    @(negedge clk);

    // R3: single step from 16'h1111 with bit 1
    step(1'b0, 1'b1, 16'h0000, 8'h00, 1'b1, "R3");
    check("R3", out1, 16'h3203);

    // R2: idle cycles with changing data
    for (int k = 0; k < 4; k++)
      step(1'b0, 1'b0, 16'(($urandom)), 8'($urandom), 1'($urandom), "R2");

    // R6: init alone
    step(1'b1, 1'b0, 16'hA5A5, 8'h5A, 1'b1, "R6");
    check("R6", out16, PRESET_A);

    // R4: known string "123456789" through the 8-bit instance
    msg = "123456789";
    for (int k = 0; k < msg.len(); k++)
      step(1'b0, 1'b1, 16'h0000, msg[k], 1'b0, "R4");
    check("R4", out8, 16'h29B1);

    // R7: init together with a word
    step(1'b1, 1'b1, 16'h3132, 8'h31, 1'b1, "R7");
    check("R7", out16, serial(PRESET_A, 16'h3132, 16));
    step(1'b1, 1'b1, 16'hFFFF, 8'hFF, 1'b0, "R7");

    // Corner words on every width
    step(1'b0, 1'b1, 16'h0000, 8'h00, 1'b0, "R8");
    step(1'b0, 1'b1, 16'hFFFF, 8'hFF, 1'b1, "R8");
    step(1'b0, 1'b1, 16'h8000, 8'h80, 1'b1, "R8");
    step(1'b0, 1'b1, 16'h0001, 8'h01, 1'b0, "R8");

    // R8 / R4: constrained random mix, mostly valid, occasional init and idle
    for (int k = 0; k < 400; k++) begin
      w = 16'($urandom);
      step(($urandom % 16) == 0, ($urandom % 8) != 0, w, 8'($urandom), 1'($urandom), "R8");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule